// File: doc/BRIEF.md
# Piecewise-Linear Gamma Curve Unit

This unit applies one gamma curve to a stream of 12-bit pixel codes. The same curve serves all three colour channels. The curve is split into 64 linear segments of unequal width. The 16 lowest codes each have a segment of their own. Above them come sectors of four segments each, and each sector's segments are twice as wide as the sector before. Once a segment reaches 128 codes, the width stays at 128 up to code 4095.

Each segment holds one coefficient word with two fields: an offset, which is the curve value at the segment's first code, and a slope pre-scaled by 256. Software loads the 64 words through an indexed write port. For each valid input code, the unit finds the segment from the position of the code's leading one, with no table search. It then reads that segment's word and computes `offset + ((slope * (code - start)) >> 8)`, clamped to 4095. The result appears two cycles after the input.

There is no back-pressure: every valid input produces exactly one valid output two cycles later.

Top module: `gamma_pwl_unit`

## Requirements
- R1: After reset, `pix_out_valid` is 0 and all 64 coefficient words are zero, so any sample then produces output 0.
- R2: `pix_out_valid` equals `pix_in_valid` delayed by exactly two clock cycles, including back-to-back samples and idle gaps.
- R3: Input codes 0..15 map to segments 0..15 respectively with zero distance from the segment start, so the output equals that segment's offset whatever its slope.
- R4: Codes 16..511 fall in sectors of four equal segments whose width is 4, 8, 16, 32 and 64 codes. Segment 16 starts at code 16, and each segment starts where the previous one ends.
- R5: Codes 512..4095 fall in 128-code segments: segment index = 32 + bits 11:7 of the code, and the segment start has bits 6:0 cleared.
- R6: The output equals `offset + ((slope * (code - start)) >> 8)` for the selected segment.
- R7: When that sum exceeds 4095, the output is 4095.
- R8: A coefficient word carries the slope in bits 27:16 and the offset in bits 11:0. Bits 31:28 and 15:12 are ignored.
- R9: A coefficient write affects samples that enter in later cycles. A sample entering in the same cycle as the write still uses the old word.
- R10: `pix_out` holds its previous value in cycles where `pix_out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| coef_we | input | 1 | Coefficient write strobe |
| coef_idx | input | 6 | Segment index of the coefficient write |
| coef_word | input | 32 | Packed coefficient word (slope 27:16, offset 11:0) |
| pix_in_valid | input | 1 | Input sample valid |
| pix_in | input | 12 | Input code |
| pix_out_valid | output | 1 | Output sample valid |
| pix_out | output | 12 | Corrected output code |

## Verification
The bench builds the unit with its default parameters: 12-bit codes, 16 unit segments, four segments per sector and a 128-code top width. With these values, all 64 segments and every sector boundary (15/16, 511/512, 4095) can be reached with a handful of directed codes. A full 4095 slope across a 127-code distance can push the sum past the output range, which exercises the clamp. The bench's segment model walks the width list from code 0 and does not decode the leading one, so it reaches the segment by a different route than the hardware does.

// File: rtl/gamma_pwl_pkg.sv
package gamma_pwl_pkg;
    localparam int CODE_W     = 12;
    localparam int SLOPE_W    = 12;
    localparam int OFFS_W     = 12;
    localparam int FRAC_SHIFT = 8;
    localparam int WORD_W     = 32;
    localparam int SLOPE_LSB  = 16;
    localparam int OFFS_LSB   = 0;

    typedef struct packed {
        logic [SLOPE_W-1:0] slope;
        logic [OFFS_W-1:0]  offs;
    } gamma_coef_t;
endpackage

// File: rtl/gamma_seg_locate.sv
module gamma_seg_locate #(
    parameter int CODE_W      = 12,
    parameter int FINE_LOG2   = 4,
    parameter int SPLIT_BITS  = 2,
    parameter int COARSE_LOG2 = 7,
    parameter int IDX_W       = 6
) (
    input  logic [CODE_W-1:0]      code,
    output logic [IDX_W-1:0]       seg_idx,
    output logic [COARSE_LOG2-1:0] seg_delta
);
    localparam int FINE_CODES   = 2 ** FINE_LOG2;
    localparam int SECTOR_SEGS  = 2 ** SPLIT_BITS;
    localparam int COARSE_MSB   = COARSE_LOG2 + SPLIT_BITS;
    localparam int COARSE_BASE  = FINE_CODES + (COARSE_MSB - FINE_LOG2) * SECTOR_SEGS;
    localparam int COARSE_SKIP  = (2 ** COARSE_MSB) >> COARSE_LOG2;

    int lead;
    int width_log2;
    int idx_i;
    int delta_i;
    int code_i;

    always_comb begin
        code_i = int'(code);
        lead = 0;
        for (int b = 0; b < CODE_W; b++) begin
            if (code[b]) lead = b;
        end
        if (code_i < FINE_CODES) begin
            width_log2 = 0;
            idx_i      = code_i;
            delta_i    = 0;
        end else if (lead >= COARSE_MSB) begin
            width_log2 = COARSE_LOG2;
            idx_i      = COARSE_BASE + (code_i >> COARSE_LOG2) - COARSE_SKIP;
            delta_i    = code_i & ((1 << COARSE_LOG2) - 1);
        end else begin
            width_log2 = lead - SPLIT_BITS;
            idx_i      = FINE_CODES + (lead - FINE_LOG2) * SECTOR_SEGS
                       + ((code_i >> width_log2) & (SECTOR_SEGS - 1));
            delta_i    = code_i & ((1 << width_log2) - 1);
        end
        seg_idx   = IDX_W'(idx_i);
        seg_delta = COARSE_LOG2'(delta_i);
    end
endmodule

// File: rtl/gamma_coef_bank.sv
module gamma_coef_bank
    import gamma_pwl_pkg::*;
#(
    parameter int NUM_SEG = 64,
    parameter int IDX_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [IDX_W-1:0]  rd_idx,
    output gamma_coef_t       rd_coef
);
    gamma_coef_t coef_q [NUM_SEG];
    gamma_coef_t wr_coef;
    logic        unused_word_bits;

    assign wr_coef.slope = wr_word[SLOPE_LSB +: SLOPE_W];
    assign wr_coef.offs  = wr_word[OFFS_LSB +: OFFS_W];
    assign unused_word_bits = ^{wr_word[WORD_W-1:SLOPE_LSB+SLOPE_W],
                                wr_word[SLOPE_LSB-1:OFFS_LSB+OFFS_W]};

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                coef_q[g] <= '0;
            end else if (wr_en && (int'(wr_idx) == g)) begin
                coef_q[g] <= wr_coef;
            end
        end
    end

    assign rd_coef = coef_q[rd_idx];

    // R8 / R9: a write lands the packed fields in the addressed entry next cycle
    p_write_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (coef_q[$past(wr_idx)].slope == $past(wr_word[SLOPE_LSB +: SLOPE_W]))
               && (coef_q[$past(wr_idx)].offs  == $past(wr_word[OFFS_LSB +: OFFS_W])));
endmodule

// File: rtl/gamma_interp.sv
module gamma_interp
    import gamma_pwl_pkg::*;
#(
    parameter int DELTA_W = 7
) (
    input  gamma_coef_t        coef,
    input  logic [DELTA_W-1:0] delta,
    output logic [CODE_W-1:0]  result
);
    localparam int PROD_W = SLOPE_W + DELTA_W;
    localparam int INCR_W = PROD_W - FRAC_SHIFT;
    localparam int SUM_W  = ((INCR_W > OFFS_W) ? INCR_W : OFFS_W) + 1;
    localparam logic [SUM_W-1:0] OUT_MAX = SUM_W'((2 ** CODE_W) - 1);

    logic [PROD_W-1:0] prod;
    logic [INCR_W-1:0] incr;
    logic [SUM_W-1:0]  sum;

    always_comb begin
        prod   = PROD_W'(coef.slope) * PROD_W'(delta);
        incr   = prod[PROD_W-1:FRAC_SHIFT];
        sum    = SUM_W'(coef.offs) + SUM_W'(incr);
        result = (sum > OUT_MAX) ? OUT_MAX[CODE_W-1:0] : sum[CODE_W-1:0];
    end

    logic unused_prod_frac;
    assign unused_prod_frac = ^prod[FRAC_SHIFT-1:0];
endmodule

// File: rtl/gamma_pwl_unit.sv
module gamma_pwl_unit
    import gamma_pwl_pkg::*;
#(
    parameter int FINE_LOG2   = 4,
    parameter int SPLIT_BITS  = 2,
    parameter int COARSE_LOG2 = 7,
    parameter int IDX_W       = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              coef_we,
    input  logic [IDX_W-1:0]  coef_idx,
    input  logic [WORD_W-1:0] coef_word,
    input  logic              pix_in_valid,
    input  logic [CODE_W-1:0] pix_in,
    output logic              pix_out_valid,
    output logic [CODE_W-1:0] pix_out
);
    localparam int COARSE_MSB  = COARSE_LOG2 + SPLIT_BITS;
    localparam int COARSE_BASE = 2 ** FINE_LOG2 + (COARSE_MSB - FINE_LOG2) * (2 ** SPLIT_BITS);
    localparam int NUM_SEG     = COARSE_BASE + ((2 ** CODE_W - 2 ** COARSE_MSB) >> COARSE_LOG2);

    logic [IDX_W-1:0]       loc_idx;
    logic [COARSE_LOG2-1:0] loc_delta;
    gamma_coef_t            rd_coef;
    logic                   s1_valid;
    gamma_coef_t            s1_coef;
    logic [COARSE_LOG2-1:0] s1_delta;
    logic [IDX_W-1:0]       s1_idx;
    logic [CODE_W-1:0]      interp_out;

    gamma_seg_locate #(
        .CODE_W(CODE_W), .FINE_LOG2(FINE_LOG2), .SPLIT_BITS(SPLIT_BITS),
        .COARSE_LOG2(COARSE_LOG2), .IDX_W(IDX_W)
    ) u_locate (
        .code(pix_in), .seg_idx(loc_idx), .seg_delta(loc_delta)
    );

    gamma_coef_bank #(.NUM_SEG(NUM_SEG), .IDX_W(IDX_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(coef_we), .wr_idx(coef_idx),
        .wr_word(coef_word), .rd_idx(loc_idx), .rd_coef(rd_coef)
    );

    // Stage 1: segment decode and coefficient fetch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_coef  <= '0;
            s1_delta <= '0;
            s1_idx   <= '0;
        end else begin
            s1_valid <= pix_in_valid;
            if (pix_in_valid) begin
                s1_coef  <= rd_coef;
                s1_delta <= loc_delta;
                s1_idx   <= loc_idx;
            end
        end
    end

    gamma_interp #(.DELTA_W(COARSE_LOG2)) u_interp (
        .coef(s1_coef), .delta(s1_delta), .result(interp_out)
    );

    // Stage 2: registered result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_out_valid <= 1'b0;
            pix_out       <= '0;
        end else begin
            pix_out_valid <= s1_valid;
            if (s1_valid) pix_out <= interp_out;
        end
    end

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pix_in_valid |=> ##1 pix_out_valid);
    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_in_valid |=> ##1 !pix_out_valid);
    p_fine_own_seg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_in_valid && pix_in < CODE_W'(2 ** FINE_LOG2))
        |=> (s1_delta == '0) && (s1_idx == IDX_W'($past(pix_in))));
    p_coarse_idx_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_in_valid && pix_in >= CODE_W'(2 ** COARSE_MSB))
        |=> (int'(s1_idx) >= COARSE_BASE));
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_valid |=> $stable(pix_out));
endmodule

// File: tb/gamma_pwl_unit_test.sv
`timescale 1ns/1ps
module gamma_pwl_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        coef_we = 1'b0;
    logic [5:0]  coef_idx = '0;
    logic [31:0] coef_word = '0;
    logic        pix_in_valid = 1'b0;
    logic [11:0] pix_in = '0;
    logic        pix_out_valid;
    logic [11:0] pix_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    int sh_slope [64];
    int sh_offs  [64];

    always #2 clk = ~clk;

    gamma_pwl_unit uut (
        .clk(clk), .rst_n(rst_n), .coef_we(coef_we), .coef_idx(coef_idx),
        .coef_word(coef_word), .pix_in_valid(pix_in_valid), .pix_in(pix_in),
        .pix_out_valid(pix_out_valid), .pix_out(pix_out)
    );

    function automatic int seg_width(int i);
        if (i < 16) return 1;
        if (i < 36) return 4 << ((i - 16) / 4);
        return 128;
    endfunction

    function automatic int seg_of(int x);
        int st = 0;
        for (int i = 0; i < 64; i++) begin
            if (x < st + seg_width(i)) return i;
            st += seg_width(i);
        end
        return -1;
    endfunction

    function automatic int start_of(int seg);
        int st = 0;
        for (int i = 0; i < seg; i++) st += seg_width(i);
        return st;
    endfunction

    function automatic int model(int x);
        int s = seg_of(x);
        int v = sh_offs[s] + ((sh_slope[s] * (x - start_of(s))) >> 8);
        return (v > 4095) ? 4095 : v;
    endfunction

    task automatic check(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_coef(int idx, int slope, int offs, logic [3:0] junk_hi, logic [3:0] junk_mid);
        @(negedge clk);
        coef_we   = 1'b1;
        coef_idx  = 6'(idx);
        coef_word = {junk_hi, 12'(slope), junk_mid, 12'(offs)};
        sh_slope[idx] = slope;
        sh_offs[idx]  = offs;
        @(negedge clk);
        coef_we = 1'b0;
    endtask

    task automatic load_curve(int k);
        for (int i = 0; i < 64; i++)
            write_coef(i, (i * 397 + k) % 4096, (i * 61 + 3 * k) % 3000, 4'h0, 4'h0);
    endtask

    // Sends one sample, checks it two cycles later
    task automatic send_check(string req, int x, int exp);
        @(negedge clk);
        pix_in_valid = 1'b1;
        pix_in = 12'(x);
        @(negedge clk);
        pix_in_valid = 1'b0;
        check({req, " valid-pre"}, int'(pix_out_valid), 0);
        @(negedge clk);
        check({req, " valid"}, int'(pix_out_valid), 1);
        check(req, int'(pix_out), exp);
    endtask

    task automatic t_reset_r1;
        check("R1 out_valid after reset", int'(pix_out_valid), 0);
        check("R1 out after reset", int'(pix_out), 0);
        send_check("R1 zero curve code 3000", 3000, 0);
        send_check("R1 zero curve code 7", 7, 0);
    endtask

    task automatic t_fine_r3;
        for (int x = 0; x < 16; x++) send_check("R3 fine code", x, sh_offs[x]);
    endtask

    task automatic t_sectors_r4;
        int codes [10] = '{16, 19, 20, 31, 32, 63, 64, 200, 256, 511};
        foreach (codes[j]) send_check("R4 sector code", codes[j], model(codes[j]));
        check("R4 segment of 20", seg_of(20), 17);
        check("R4 segment of 511", seg_of(511), 35);
    endtask

    task automatic t_coarse_r5;
        int codes [6] = '{512, 639, 640, 2047, 4000, 4095};
        foreach (codes[j]) send_check("R5 coarse code", codes[j], model(codes[j]));
    endtask

    task automatic t_formula_r6;
        write_coef(40, 512, 100, 4'h0, 4'h0);
        // segment 40 starts at 1024: 100 + (512*50)>>8 = 200
        send_check("R6 interp 1074", 1074, 200);
        write_coef(20, 300, 7, 4'h0, 4'h0);
        // segment 20 starts at 32 width 8: 7 + (300*5)>>8 = 12
        send_check("R6 interp 37", 37, 12);
    endtask

    task automatic t_sat_r7;
        write_coef(63, 4095, 4000, 4'h0, 4'h0);
        send_check("R7 saturate 4095", 4095, 4095);
        send_check("R7 no saturate at start", 3968, 4000);
    endtask

    task automatic t_fields_r8;
        write_coef(50, 256, 1000, 4'hF, 4'hA);
        // segment 50 starts at 2304; delta 10 -> 1000 + 10 = 1010
        send_check("R8 junk bits ignored", 2314, 1010);
    endtask

    task automatic t_write_timing_r9;
        int old_v;
        old_v = sh_offs[5];
        @(negedge clk);
        coef_we = 1'b1; coef_idx = 6'd5; coef_word = {4'h0, 12'd0, 4'h0, 12'd777};
        pix_in_valid = 1'b1; pix_in = 12'd5;
        @(negedge clk);
        coef_we = 1'b0;
        sh_offs[5] = 777;
        pix_in = 12'd5;
        @(negedge clk);
        pix_in_valid = 1'b0;
        check("R9 same-cycle write uses old", int'(pix_out), old_v);
        check("R2 stream valid", int'(pix_out_valid), 1);
        @(negedge clk);
        check("R9 later sample uses new", int'(pix_out), 777);
    endtask

    task automatic t_stream_r2_r10;
        int codes [8] = '{0, 17, 100, 600, 4095, 9, 300, 1500};
        int exp_q [8];
        foreach (codes[j]) exp_q[j] = model(codes[j]);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (k >= 2) begin
                check("R2 back-to-back valid", int'(pix_out_valid), 1);
                check("R6 stream value", int'(pix_out), exp_q[k - 2]);
            end
            pix_in_valid = (k < 8);
            pix_in = (k < 8) ? 12'(codes[k]) : 12'd0;
        end
        pix_in_valid = 1'b0;
        @(negedge clk);
        check("R2 idle after stream", int'(pix_out_valid), 0);
        check("R10 hold value", int'(pix_out), exp_q[7]);
        @(negedge clk);
        check("R10 hold value again", int'(pix_out), exp_q[7]);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin sh_slope[i] = 0; sh_offs[i] = 0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_r1();
        load_curve(5);
        t_fine_r3();
        t_sectors_r4();
        t_coarse_r5();
        t_formula_r6();
        t_sat_r7();
        t_fields_r8();
        t_write_timing_r9();
        t_stream_r2_r10();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R2 watchdog actual=hung expected=complete");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule